// File: doc/BRIEF.md
# Link Quality Threshold Monitor

The block watches five signed receiver quality parameters sampled from the equalizer and clock recovery path: frequency control, frequency offset, baseline wander, gain, and one equalizer coefficient. Each parameter has its own programmable upper and lower bound. When a valid sample rises strictly above its upper bound or drops strictly below its lower bound, a sticky warning bit for that bound is set. Monitoring is live only while the monitor is switched on and the link qualifier reports a valid high-speed link.

Software reaches the block through a small register port. Address 0 is the control/status word, which holds the monitor switch and the ten warning flags. Reading it clears the flags and re-arms the interrupt. Addresses 1 to 10 hold the ten bounds. An interrupt request is produced as a single one-cycle pulse per arming. The pulse fires when a warning is present and the external interrupt enable is high. After that the request stays quiet until the next read of the control word. Programming a bound to the extreme value of its signed range switches that individual check off.

Top module: `lqm_monitor`

## Requirements
- R1: After reset the monitor switch is 0, all warnings are 0, `irq` is 0, every upper bound holds the largest positive sample value and every lower bound holds the most negative sample value.
- R2: In the control word, bit 15 is the read/write monitor switch. Bits 14:10 always read 0 and ignore writes. Bits 9:0 are the warnings, and writes to them have no effect.
- R3: Warning bit positions are 9/8 frequency control upper/lower, 7/6 frequency offset upper/lower, 5/4 baseline wander upper/lower, 3/2 gain upper/lower, and 1/0 coefficient upper/lower. Sample lane i occupies `smp_data[i*SW +: SW]` in that same parameter order, starting with i=0 for frequency control.
- R4: Comparisons are signed and strict. A sample greater than its upper bound sets the upper warning, and a sample less than its lower bound sets the lower warning. A sample equal to a bound sets nothing.
- R5: A sample is only checked when `smp_valid`, `link_up` and the monitor switch are all 1. In every other case no new warning appears.
- R6: An upper bound at the most positive value, or a lower bound at the most negative value, never sets its warning.
- R7: Warnings stay set until a read of the control word (`reg_rd` with `reg_addr` 0), which clears them at that clock edge.
- R8: A violation detected in the same cycle as a clearing read leaves its warning set after the read.
- R9: When the block is armed, `irq_enable` is 1 and any warning is set, `irq` pulses high for exactly one cycle and the block disarms. A control read re-arms it. A read cycle itself never fires the pulse.
- R10: The bound at address 1+2i is the upper bound and the bound at address 2+2i is the lower bound of parameter i. Each is written from the low SW bits of `reg_wdata` and reads back sign-extended to 16 bits.
- R11: `reg_rdata` follows `reg_addr` combinationally. Addresses 11 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears warnings at address 0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| link_up | input | 1 | Valid high-speed link qualifier |
| irq_enable | input | 1 | Interrupt enable for this source |
| smp_valid | input | 1 | Sample strobe for all five lanes |
| smp_data | input | 5*SW | Five signed parameter samples, lane 0 in the low bits |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The embedded properties assume that every register and sample input is a known value from the first clock edge. They also assume that a clearing read is marked only by `reg_rd` at address 0. The bench meets this by driving all inputs to defined values at time zero and only ever changing them half a cycle away from the active edge. Random samples are aimed at each lane's current bounds: one step above, one step below, exactly on the bound, or far away. This keeps both the strict-compare edge and the extreme-bound case in regular use. Bound writes stay inside the SW-bit range, and the link and enable inputs are toggled at random so that inactive cycles occur often.

// File: rtl/lqm_pkg.sv
// Package: shared constants and bit-position helpers for the link quality
// threshold monitor. Assumes exactly five monitored parameters.
package lqm_pkg;
    localparam int NPARAM     = 5;
    localparam int NWARN      = 2 * NPARAM;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 4;
    localparam int CTRL_EN    = 15;
    localparam int CTRL_ADDR  = 0;
    localparam int THR_BASE   = 1;

    // Warning flag position of the upper bound of lane i (lane 0 is highest).
    function automatic int hi_bit(input int lane);
        return 2 * (NPARAM - 1 - lane) + 1;
    endfunction

    // Warning flag position of the lower bound of lane i.
    function automatic int lo_bit(input int lane);
        return 2 * (NPARAM - 1 - lane);
    endfunction
endpackage

// File: rtl/lqm_thresh_bank.sv
// Threshold bank: holds an upper and a lower signed bound per lane, writable
// and readable through the register port at addresses THR_BASE..THR_BASE+2N-1.
// Assumes SW <= 16. Bounds reset to the extremes, which disables every check.
module lqm_thresh_bank
    import lqm_pkg::*;
#(
    parameter int SW = 12,
    parameter int NP = NPARAM
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [NP*SW-1:0]     thr_hi,
    output logic [NP*SW-1:0]     thr_lo,
    output logic                 rd_hit,
    output logic [REG_W-1:0]     rd_data
);
    localparam logic [SW-1:0] MAX_VAL = {1'b0, {(SW-1){1'b1}}};
    localparam logic [SW-1:0] MIN_VAL = {1'b1, {(SW-1){1'b0}}};
    localparam int            NREG    = 2 * NP;

    logic [SW-1:0] bound_q [NREG];

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_reg
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(THR_BASE + k);
            localparam logic [SW-1:0]     RST_VAL = (k % 2 == 0) ? MAX_VAL : MIN_VAL;

            // Load this bound on a write to its address.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bound_q[k] <= RST_VAL;
                else if (wr_en && addr == MY_ADDR)
                    bound_q[k] <= wr_data[SW-1:0];
            end
        end

        for (genvar i = 0; i < NP; i++) begin : g_out
            assign thr_hi[i*SW +: SW] = bound_q[2*i];
            assign thr_lo[i*SW +: SW] = bound_q[2*i+1];
        end
    endgenerate

    // Read mux with sign extension; flags whether the address is a bound.
    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        for (int k = 0; k < NREG; k++) begin
            if (addr == ADDR_W'(THR_BASE + k)) begin
                rd_hit  = 1'b1;
                rd_data = REG_W'($signed(bound_q[k]));
            end
        end
    end
endmodule

// File: rtl/lqm_cmp_lane.sv
// Compare lane: strict signed comparison of one sample against its bounds.
// Assumes the bounds are stable values from registers; output is combinational.
module lqm_cmp_lane #(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          check_en,
    input  logic [SW-1:0] sample,
    input  logic [SW-1:0] bound_hi,
    input  logic [SW-1:0] bound_lo,
    output logic          over,
    output logic          under
);
    localparam logic [SW-1:0] MAX_VAL = {1'b0, {(SW-1){1'b1}}};
    localparam logic [SW-1:0] MIN_VAL = {1'b1, {(SW-1){1'b0}}};

    // Signed strict comparison, gated by the active-check qualifier.
    always_comb begin
        over  = check_en && ($signed(sample) > $signed(bound_hi));
        under = check_en && ($signed(sample) < $signed(bound_lo));
    end

    AST_HI_MAX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_hi == MAX_VAL) |-> !over); // R6
    AST_LO_MIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_lo == MIN_VAL) |-> !under); // R6
    AST_EQUAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample == bound_hi || sample == bound_lo) |-> !(over && under)); // R4
    AST_EQ_HI_NO_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (sample == bound_hi) |-> !over); // R4
endmodule

// File: rtl/lqm_warn_ctrl.sv
// Warning and interrupt control: sticky warning flags, the monitor switch,
// and a one-shot interrupt that re-arms on each clearing read.
// Assumes viol is already qualified by the active-check condition.
module lqm_warn_ctrl
    import lqm_pkg::*;
#(
    parameter int NW = NWARN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] viol,
    input  logic          clr,
    input  logic          en_wr,
    input  logic          en_wdata,
    input  logic          irq_en,
    output logic          mon_en,
    output logic [NW-1:0] warn,
    output logic          irq
);
    logic armed_q;
    logic fire;

    // Fire once when armed, enabled and a warning is pending, never on a read.
    always_comb fire = armed_q && irq_en && (|warn) && !clr;

    // Sticky warnings: read clears, same-cycle violations win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warn <= '0;
        else
            warn <= (clr ? '0 : warn) | viol;
    end

    // Monitor switch register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mon_en <= 1'b0;
        else if (en_wr)
            mon_en <= en_wdata;
    end

    // Arming state: a read re-arms, a pulse disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else if (clr)
            armed_q <= 1'b1;
        else if (fire)
            armed_q <= 1'b0;
    end

    // Registered interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= fire;
    end

    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(warn) & ~warn) == '0)); // R7
    AST_READ_RACE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((warn & $past(viol)) == $past(viol))); // R8
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en)); // R9
    AST_IRQ_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !irq); // R9
endmodule

// File: rtl/lqm_monitor.sv
// Top: link quality threshold monitor. Ties the threshold bank, five compare
// lanes and the warning/interrupt controller to a simple register port.
// Assumes one register access per cycle and SW <= 16.
module lqm_monitor
    import lqm_pkg::*;
#(
    parameter int SW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  link_up,
    input  logic                  irq_enable,
    input  logic                  smp_valid,
    input  logic [NPARAM*SW-1:0]  smp_data,
    output logic                  irq
);
    localparam int RSV_W = CTRL_EN - NWARN;

    logic [NPARAM*SW-1:0] thr_hi;
    logic [NPARAM*SW-1:0] thr_lo;
    logic                 bank_hit;
    logic [REG_W-1:0]     bank_rdata;
    logic [NPARAM-1:0]    over;
    logic [NPARAM-1:0]    under;
    logic [NWARN-1:0]     viol;
    logic [NWARN-1:0]     warn;
    logic                 mon_en;
    logic                 check_en;
    logic                 ctrl_sel;
    logic                 ctrl_clr;
    logic                 ctrl_wr;

    // Decode control-word accesses and the active-check qualifier.
    always_comb begin
        ctrl_sel = (reg_addr == ADDR_W'(CTRL_ADDR));
        ctrl_clr = reg_rd && ctrl_sel;
        ctrl_wr  = reg_wr && ctrl_sel;
        check_en = smp_valid && link_up && mon_en;
    end

    lqm_thresh_bank #(.SW(SW), .NP(NPARAM)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .thr_hi  (thr_hi),
        .thr_lo  (thr_lo),
        .rd_hit  (bank_hit),
        .rd_data (bank_rdata)
    );

    generate
        for (genvar i = 0; i < NPARAM; i++) begin : g_lane
            lqm_cmp_lane #(.SW(SW)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .check_en (check_en),
                .sample   (smp_data[i*SW +: SW]),
                .bound_hi (thr_hi[i*SW +: SW]),
                .bound_lo (thr_lo[i*SW +: SW]),
                .over     (over[i]),
                .under    (under[i])
            );
            assign viol[hi_bit(i)] = over[i];
            assign viol[lo_bit(i)] = under[i];
        end
    endgenerate

    lqm_warn_ctrl #(.NW(NWARN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .viol     (viol),
        .clr      (ctrl_clr),
        .en_wr    (ctrl_wr),
        .en_wdata (reg_wdata[CTRL_EN]),
        .irq_en   (irq_enable),
        .mon_en   (mon_en),
        .warn     (warn),
        .irq      (irq)
    );

    // Read data mux: control word, bound registers, or zero.
    always_comb begin
        if (ctrl_sel)
            reg_rdata = {mon_en, {RSV_W{1'b0}}, warn};
        else if (bank_hit)
            reg_rdata = bank_rdata;
        else
            reg_rdata = '0;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sel |-> (reg_rdata[CTRL_EN-1:NWARN] == '0)); // R2
    AST_IDLE_NO_NEW_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && link_up && mon_en) |=> ((warn & ~$past(warn)) == '0)); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(2*NPARAM)) |-> (reg_rdata == '0)); // R11
endmodule

// File: tb/lqm_monitor_test.sv
// Bench: fixed-seed random stimulus plus directed corners, compared each
// cycle against a behavioural model built from the requirements.
module lqm_monitor_test;
    localparam int SW   = 12;
    localparam int NP   = 5;
    localparam int MAXV = (1 << (SW-1)) - 1;
    localparam int MINV = -(1 << (SW-1));

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic            link_up = 1'b0;
    logic            irq_enable = 1'b0;
    logic            smp_valid = 1'b0;
    logic [NP*SW-1:0] smp_data = '0;
    logic            irq;

    int   vectors = 0;
    int   fails = 0;
    bit   done = 1'b0;

    int       cur_s [NP];
    int       m_hi  [NP];
    int       m_lo  [NP];
    bit [9:0] m_warn;
    bit       m_en, m_armed, m_irq;

    always #2.5 clk = ~clk;

    lqm_monitor #(.SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_up(link_up), .irq_enable(irq_enable), .smp_valid(smp_valid),
        .smp_data(smp_data), .irq(irq)
    );

    function automatic int clampv(input int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic int sx(input logic [SW-1:0] v);
        return int'($signed(v));
    endfunction

    // Expected read data (R2, R10, R11).
    function automatic logic [15:0] exp_read(input logic [3:0] a);
        int k;
        if (a == 0) return {m_en, 5'b0, m_warn};
        if (a >= 1 && a <= 10) begin
            k = int'(a) - 1;
            return 16'((k % 2 == 0) ? m_hi[k/2] : m_lo[k/2]);
        end
        return 16'h0000;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model update at a clock edge (R4-R9, R2, R10).
    task automatic model_edge();
        bit       clr, fire, act;
        bit [9:0] viol;
        clr  = reg_rd && reg_addr == 0;
        fire = m_armed && irq_enable && (m_warn != 0) && !clr;
        act  = smp_valid && link_up && m_en;
        viol = '0;
        for (int i = 0; i < NP; i++) begin
            if (act && cur_s[i] > m_hi[i]) viol[2*(NP-1-i)+1] = 1'b1;
            if (act && cur_s[i] < m_lo[i]) viol[2*(NP-1-i)]   = 1'b1;
        end
        m_warn = (clr ? 10'b0 : m_warn) | viol;
        if (clr) m_armed = 1'b1;
        else if (fire) m_armed = 1'b0;
        m_irq = fire;
        if (reg_wr && reg_addr == 0) m_en = reg_wdata[15];
        if (reg_wr && reg_addr >= 1 && reg_addr <= 10) begin
            int k = int'(reg_addr) - 1;
            if (k % 2 == 0) m_hi[k/2] = sx(reg_wdata[SW-1:0]);
            else            m_lo[k/2] = sx(reg_wdata[SW-1:0]);
        end
    endtask

    // One cycle: drive at negedge, check reads, clock, check irq.
    task automatic step(input string tag);
        for (int i = 0; i < NP; i++) smp_data[i*SW +: SW] = SW'(cur_s[i]);
        #1;
        if (reg_rd) check({tag, " R11 read"}, reg_rdata, exp_read(reg_addr));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " R9 irq"}, {15'b0, irq}, {15'b0, m_irq});
    endtask

    task automatic idle_inputs();
        reg_wr = 0; reg_rd = 0; smp_valid = 0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d, input string tag);
        idle_inputs(); reg_addr = a; reg_wdata = d; reg_wr = 1; step(tag);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [3:0] a, input string tag);
        idle_inputs(); reg_addr = a; reg_rd = 1; step(tag);
        reg_rd = 0;
    endtask

    task automatic sample_all(input int v0, input int v1, input int v2, input int v3,
                              input int v4, input string tag);
        idle_inputs(); reg_addr = 4'd15;
        cur_s[0] = v0; cur_s[1] = v1; cur_s[2] = v2; cur_s[3] = v3; cur_s[4] = v4;
        smp_valid = 1; step(tag);
        smp_valid = 0;
    endtask

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NP; i++) begin
            cur_s[i] = 0; m_hi[i] = MAXV; m_lo[i] = MINV;
        end
        m_warn = '0; m_en = 0; m_armed = 1; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state.
        check("R1 irq", {15'b0, irq}, 16'h0);
        for (int a = 0; a < 16; a++) rd_reg(4'(a), "R1 reset readback");

        // R6: extremes never trigger, even with full-range samples.
        link_up = 1; irq_enable = 1;
        wr_reg(0, 16'h8000, "R2 enable");
        sample_all(MAXV, MINV, MAXV, MINV, MAXV, "R6 extreme");
        rd_reg(0, "R6 no warn");

        // R2: reserved and warning bits ignore writes.
        wr_reg(0, 16'hFFFF, "R2 write all ones");
        rd_reg(0, "R2 reserved zero");

        // R10: program bounds, read them back.
        for (int i = 0; i < NP; i++) begin
            wr_reg(4'(1+2*i), 16'(100 + 10*i), "R10 hi");
            wr_reg(4'(2+2*i), 16'(-100 - 10*i), "R10 lo");
        end
        for (int a = 1; a <= 10; a++) rd_reg(4'(a), "R10 readback");

        // R4: equal samples set nothing; one step beyond sets the bit (R3 order).
        sample_all(100, -110, 120, -130, 140, "R4 equal");
        rd_reg(0, "R4 equal no warn");
        sample_all(101, 0, 0, 0, 0, "R3 fc hi");
        rd_reg(0, "R3 bit9");
        sample_all(0, 0, 0, 0, -141, "R3 coef lo");
        rd_reg(0, "R3 bit0");

        // R5: link down or monitor off blocks checking.
        link_up = 0;
        sample_all(2000, 2000, 2000, 2000, 2000, "R5 link down");
        rd_reg(0, "R5 link down readback");
        link_up = 1;
        wr_reg(0, 16'h0000, "R5 disable");
        sample_all(-2000, -2000, -2000, -2000, -2000, "R5 off");
        rd_reg(0, "R5 off readback");
        wr_reg(0, 16'h8000, "R5 reenable");

        // R8: violation during the clearing read survives.
        idle_inputs(); reg_addr = 0; reg_rd = 1; smp_valid = 1;
        for (int i = 0; i < NP; i++) cur_s[i] = 500;
        step("R8 race");
        rd_reg(0, "R8 kept");

        // R9: single pulse, quiet until re-armed (R7 sticky).
        sample_all(-500, 0, 0, 0, 0, "R9 trig");
        repeat (4) begin idle_inputs(); step("R9 quiet"); end
        sample_all(0, -500, 0, 0, 0, "R9 more warn");
        repeat (3) begin idle_inputs(); step("R7 sticky"); end
        rd_reg(0, "R7 clear");
        sample_all(0, 0, 900, 0, 0, "R9 rearmed");
        repeat (3) begin idle_inputs(); step("R9 second pulse"); end

        // Random phase.
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle_inputs();
            link_up    = ($urandom % 10) != 0;
            irq_enable = ($urandom % 5) != 0;
            smp_valid  = ($urandom % 10) < 7;
            for (int i = 0; i < NP; i++) begin
                case ($urandom % 5)
                    0: cur_s[i] = clampv(m_hi[i] + int'($urandom % 3) - 1);
                    1: cur_s[i] = clampv(m_lo[i] + int'($urandom % 3) - 1);
                    2: cur_s[i] = int'($urandom % (1 << SW)) + MINV;
                    3: cur_s[i] = (($urandom % 2) != 0) ? MAXV : MINV;
                    default: cur_s[i] = 0;
                endcase
            end
            r = int'($urandom % 100);
            reg_addr = 4'($urandom % 16);
            if (r < 12) begin
                reg_addr = 0; reg_rd = 1;
            end else if (r < 15) begin
                reg_addr = 0; reg_wr = 1;
                reg_wdata = 16'($urandom);
                if (($urandom % 4) != 0) reg_wdata[15] = 1'b1;
            end else if (r < 19) begin
                reg_addr = 4'(1 + $urandom % 10);
                reg_wr = 1;
                case ($urandom % 4)
                    0: reg_wdata = 16'(MAXV);
                    1: reg_wdata = 16'(MINV);
                    default: reg_wdata = 16'(int'($urandom % 801) - 400);
                endcase
            end else if (r < 24) begin
                reg_rd = 1;
            end
            step("R4 R7 R9 random");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule